// File: doc/BRIEF.md
# Operand Descriptor Byte Parser

This block sits behind an instruction opcode decoder. Once the decoder knows that the current opcode carries a register/memory operand descriptor, it pulses `start_i` and hands over the byte seen ahead of the opcode, if there was one. From then on the parser accepts the bytes that follow the opcode, one per cycle in which `byte_valid_i` is high. The parser itself decides how many bytes the operand encoding spans. It reads the descriptor byte, then an optional scale/index/base byte, then a displacement of zero, one or four bytes.

When the last byte of the encoding has been accepted, the parser raises `done_o` for one cycle. During that cycle the outputs present the decoded register numbers, the addressing fields, the sign-extended or little-endian displacement and the number of bytes consumed. In 64-bit operation, a prefix byte in the range 0x40–0x4F adds a fourth, most significant bit to the register numbers, so that sixteen registers can be named. In 32-bit operation the same byte values carry no meaning for the parser.

Top module: `opnd_desc_parser`

## Requirements
- R1: The first byte accepted after a start splits into mode = bits 7:6, reg = bits 5:3 and r/m = bits 2:0. `mod_o` reports the mode, and the low three bits of `reg_o` and `rm_o` report reg and r/m.
- R2: Mode 11 (register direct) completes after the descriptor byte alone. It reports length 1, no SIB byte, a displacement of 0 and `base_valid_o` low.
- R3: Mode 01 takes one displacement byte, which appears sign-extended on `disp_o`. Mode 10 takes four displacement bytes, assembled with the first byte received as the least significant.
- R4: Mode 00 takes no displacement, with one exception. When r/m is 101, a four-byte displacement follows and `base_valid_o` is low. For any other r/m value that is not 100, the base is the r/m register and `base_valid_o` is high.
- R5: In modes 00, 01 and 10, an r/m value of 100 means a SIB byte follows the descriptor. That byte splits into scale = bits 7:6, index = bits 5:3 and base = bits 2:0. An index of 100 with the index extension bit clear means there is no index (`index_valid_o` low).
- R6: With a SIB byte in mode 00, a base value of 101 means there is no base, and a four-byte displacement follows. In modes 01 and 10, base 101 names a real base register, and the displacement size is set by the mode.
- R7: When `long_mode_i` is high and the prefix byte given at the start lies in 0x40–0x4F, its bit 2 becomes bit 3 of `reg_o`. Its bit 1 becomes bit 3 of `index_o`, and its bit 0 becomes bit 3 of `rm_o` and `base_o`. When `long_mode_i` is low, or the prefix byte lies outside that range, every bit 3 is 0.
- R8: `done_o` rises in the cycle after the edge that accepts the final byte of the encoding, and stays high for exactly one cycle. `len_o` then equals the number of bytes consumed, from 1 to 6. After that, bytes are ignored until the next start.
- R9: A start strobe during a parse abandons that parse and gives no `done_o`. Parsing restarts with the descriptor byte. A byte presented in the same cycle as the start strobe is not consumed.
- R10: Cycles with `byte_valid_i` low neither advance the parse nor change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_mode_i | input | 1 | 1 = 64-bit operation, 0 = 32-bit; sampled with start |
| start_i | input | 1 | Begin (or restart) a parse |
| prefix_i | input | 8 | Byte seen ahead of the opcode, sampled with start |
| byte_valid_i | input | 1 | `byte_i` holds the next operand byte |
| byte_i | input | 8 | Operand byte |
| done_o | output | 1 | One-cycle completion pulse |
| mod_o | output | 2 | Mode field |
| reg_o | output | 4 | Extended reg register number |
| rm_o | output | 4 | Extended r/m field |
| has_sib_o | output | 1 | A SIB byte was consumed |
| scale_o | output | 2 | SIB scale (shift amount) |
| index_o | output | 4 | Extended index register number |
| index_valid_o | output | 1 | An index register is in use |
| base_o | output | 4 | Extended base register number |
| base_valid_o | output | 1 | A base register is in use |
| disp_o | output | DISP_W | Displacement, sign-extended when one byte |
| len_o | output | 3 | Bytes consumed (descriptor, SIB, displacement) |

## Verification
The bench builds the parser with the default 32-bit displacement width. This gives four-byte displacements and the full range of lengths from 1 to 6, including the longest case: a SIB byte followed by a four-byte displacement. Random descriptor, SIB and prefix bytes, in both operating modes and with random stall cycles between bytes, reach every combination of mode and escape code. Directed cases cover the negative one-byte displacement, the forced-displacement escape codes, the extended "no index" case, the abort on restart and the ignored bytes in idle.

// File: rtl/opnd_desc_parser.sv
module opnd_desc_parser #(
  parameter int DISP_W = 32,
  localparam int DISP_BYTES = DISP_W / 8,
  localparam int LEN_W = $clog2(DISP_BYTES + 3),
  localparam int CNT_W = $clog2(DISP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_mode_i,
  input  logic              start_i,
  input  logic [7:0]        prefix_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              done_o,
  output logic [1:0]        mod_o,
  output logic [3:0]        reg_o,
  output logic [3:0]        rm_o,
  output logic              has_sib_o,
  output logic [1:0]        scale_o,
  output logic [3:0]        index_o,
  output logic              index_valid_o,
  output logic [3:0]        base_o,
  output logic              base_valid_o,
  output logic [DISP_W-1:0] disp_o,
  output logic [LEN_W-1:0]  len_o
);

  typedef enum logic [1:0] {S_IDLE, S_DESC, S_SIB, S_DISP} st_t;

  st_t               st;
  logic [1:0]        mod_q;
  logic [2:0]        reg_q, rm_q, idx_q, bas_q;
  logic [1:0]        scl_q;
  logic [3:0]        ext_q;
  logic              sib_q, short_q, done_q;
  logic [DISP_W-1:0] disp_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  left_q;

  logic [1:0]       b_mod;
  logic [2:0]       b_lo;
  logic             d_sib;
  logic [CNT_W-1:0] d_dn, s_dn;

  assign b_mod = byte_i[7:6];
  assign b_lo  = byte_i[2:0];
  assign d_sib = (b_mod != 2'b11) && (b_lo == 3'b100);

  always_comb begin
    d_dn = '0;
    if (b_mod == 2'b01) d_dn = CNT_W'(1);
    else if (b_mod == 2'b10) d_dn = CNT_W'(DISP_BYTES);
    else if (b_mod == 2'b00 && b_lo == 3'b101) d_dn = CNT_W'(DISP_BYTES);
    s_dn = '0;
    if (mod_q == 2'b01) s_dn = CNT_W'(1);
    else if (mod_q == 2'b10) s_dn = CNT_W'(DISP_BYTES);
    else if (b_lo == 3'b101) s_dn = CNT_W'(DISP_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done_q <= 1'b0; mod_q <= '0; reg_q <= '0; rm_q <= '0;
      idx_q <= '0; bas_q <= '0; scl_q <= '0; ext_q <= '0; sib_q <= 1'b0;
      short_q <= 1'b0; disp_q <= '0; len_q <= '0; left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        st      <= S_DESC;
        ext_q   <= (long_mode_i && prefix_i[7:4] == 4'h4) ? prefix_i[3:0] : 4'h0;
        len_q   <= '0;
        disp_q  <= '0;
        sib_q   <= 1'b0;
        short_q <= 1'b0;
        scl_q   <= '0; idx_q <= '0; bas_q <= '0;
      end else if (byte_valid_i) begin
        case (st)
          S_DESC: begin
            mod_q   <= b_mod;
            reg_q   <= byte_i[5:3];
            rm_q    <= b_lo;
            short_q <= (b_mod == 2'b01);
            len_q   <= LEN_W'(1);
            if (d_sib) st <= S_SIB;
            else if (d_dn != '0) begin st <= S_DISP; left_q <= d_dn; end
            else begin st <= S_IDLE; done_q <= 1'b1; end
          end
          S_SIB: begin
            sib_q <= 1'b1;
            scl_q <= byte_i[7:6];
            idx_q <= byte_i[5:3];
            bas_q <= b_lo;
            len_q <= len_q + LEN_W'(1);
            if (s_dn != '0) begin st <= S_DISP; left_q <= s_dn; end
            else begin st <= S_IDLE; done_q <= 1'b1; end
          end
          S_DISP: begin
            disp_q <= {byte_i, disp_q[DISP_W-1:8]};
            len_q  <= len_q + LEN_W'(1);
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin st <= S_IDLE; done_q <= 1'b1; end
          end
          default: ;
        endcase
      end
    end
  end

  assign done_o        = done_q;
  assign mod_o         = mod_q;
  assign reg_o         = {ext_q[2], reg_q};
  assign rm_o          = {ext_q[0], rm_q};
  assign has_sib_o     = sib_q;
  assign scale_o       = scl_q;
  assign index_o       = {ext_q[1], idx_q};
  assign index_valid_o = sib_q && !(!ext_q[1] && idx_q == 3'b100);
  assign base_o        = sib_q ? {ext_q[0], bas_q} : {ext_q[0], rm_q};
  assign base_valid_o  = (mod_q != 2'b11) &&
                         !(mod_q == 2'b00 && (sib_q ? bas_q == 3'b101 : rm_q == 3'b101));
  assign disp_o        = short_q ? DISP_W'($signed(disp_q) >>> (DISP_W - 8)) : disp_q;
  assign len_o         = len_q;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_o >= LEN_W'(1) && len_o <= LEN_W'(DISP_BYTES + 2)));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start_i) |=> !done_o);
  a_r9_start_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);
  a_r2_direct_short: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mod_o == 2'b11) |-> (len_o == LEN_W'(1) && !has_sib_o && disp_o == '0));
  a_r3_disp8_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mod_o == 2'b01) |->
      ($countones(disp_o[DISP_W-1:7]) == 0 || $countones(disp_o[DISP_W-1:7]) == DISP_W - 7));
  a_r5_sib_escape: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && has_sib_o) |-> (mod_o != 2'b11 && rm_o[2:0] == 3'b100));

endmodule

// File: tb/opnd_desc_parser_test.sv
module opnd_desc_parser_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        long_mode_i = 1'b0, start_i = 1'b0, byte_valid_i = 1'b0;
  logic [7:0]  prefix_i = 8'h00, byte_i = 8'h00;
  logic        done_o, has_sib_o, index_valid_o, base_valid_o;
  logic [1:0]  mod_o, scale_o;
  logic [3:0]  reg_o, rm_o, index_o, base_o;
  logic [31:0] disp_o;
  logic [2:0]  len_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  opnd_desc_parser uut (
    .clk(clk), .rst_n(rst_n), .long_mode_i(long_mode_i), .start_i(start_i),
    .prefix_i(prefix_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .done_o(done_o), .mod_o(mod_o), .reg_o(reg_o), .rm_o(rm_o),
    .has_sib_o(has_sib_o), .scale_o(scale_o), .index_o(index_o),
    .index_valid_o(index_valid_o), .base_o(base_o), .base_valid_o(base_valid_o),
    .disp_o(disp_o), .len_o(len_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_start(input logic lm, input [7:0] pfx);
    long_mode_i = lm; prefix_i = pfx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic parse(input logic lm, input [7:0] pfx, input [7:0] desc,
                       input [7:0] sib, input [31:0] disp, input bit gaps, input string tag);
    logic [3:0] ext;
    logic [1:0] m;
    bit nsib, early, bv, iv;
    int dn, n;
    logic [7:0] seq [6];
    logic [31:0] edisp;
    logic [3:0] ebase;
    ext = (lm && pfx[7:4] == 4'h4) ? pfx[3:0] : 4'h0;
    m = desc[7:6];
    nsib = (m != 2'b11) && (desc[2:0] == 3'b100);
    if (m == 2'b01) dn = 1;
    else if (m == 2'b10) dn = 4;
    else if (m == 2'b00 && !nsib && desc[2:0] == 3'b101) dn = 4;
    else if (m == 2'b00 && nsib && sib[2:0] == 3'b101) dn = 4;
    else dn = 0;
    n = 0;
    seq[n++] = desc;
    if (nsib) seq[n++] = sib;
    for (int k = 0; k < dn; k++) seq[n++] = disp[8*k +: 8];
    edisp = (dn == 0) ? 32'h0 : (dn == 1) ? {{24{disp[7]}}, disp[7:0]} : disp;
    ebase = nsib ? {ext[0], sib[2:0]} : {ext[0], desc[2:0]};
    bv = (m != 2'b11) && !(m == 2'b00 && (nsib ? sib[2:0] == 3'b101 : desc[2:0] == 3'b101));
    iv = nsib && !(!ext[1] && sib[5:3] == 3'b100);
    do_start(lm, pfx);
    early = 0;
    for (int k = 0; k < n; k++) begin
      if (gaps) begin
        byte_valid_i = 1'b0; byte_i = $urandom;
        repeat ($urandom % 3) begin @(negedge clk); if (done_o) early = 1; end
      end
      byte_valid_i = 1'b1; byte_i = seq[k];
      @(negedge clk);
      if (k != n - 1 && done_o) early = 1;
    end
    byte_valid_i = 1'b0;
    chk(!early, "R10", {tag, " no early done"}, 32'(early), 0);
    chk(done_o, "R8", {tag, " done after last byte"}, 32'(done_o), 1);
    chk(len_o == 3'(n), "R8", {tag, " length"}, 32'(len_o), 32'(n));
    chk(mod_o == m, "R1", {tag, " mode"}, 32'(mod_o), 32'(m));
    chk(reg_o == {ext[2], desc[5:3]}, "R7", {tag, " reg"}, 32'(reg_o), 32'({ext[2], desc[5:3]}));
    chk(rm_o == {ext[0], desc[2:0]}, "R1", {tag, " rm"}, 32'(rm_o), 32'({ext[0], desc[2:0]}));
    chk(has_sib_o == nsib, "R5", {tag, " sib flag"}, 32'(has_sib_o), 32'(nsib));
    chk(disp_o == edisp, "R3", {tag, " displacement"}, disp_o, edisp);
    chk(base_valid_o == bv, "R6", {tag, " base valid"}, 32'(base_valid_o), 32'(bv));
    if (bv) chk(base_o == ebase, "R4", {tag, " base"}, 32'(base_o), 32'(ebase));
    chk(index_valid_o == iv, "R5", {tag, " index valid"}, 32'(index_valid_o), 32'(iv));
    if (nsib) begin
      chk(scale_o == sib[7:6], "R5", {tag, " scale"}, 32'(scale_o), 32'(sib[7:6]));
      chk(index_o == {ext[1], sib[5:3]}, "R7", {tag, " index"}, 32'(index_o), 32'({ext[1], sib[5:3]}));
    end
    @(negedge clk);
    chk(!done_o, "R8", {tag, " single pulse"}, 32'(done_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit seen;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && len_o == 0, "R8", "reset state", {28'h0, done_o, len_o}, 0);

    parse(0, 8'h00, 8'hD9, 8'h00, 32'h0, 0, "R2 direct");
    parse(0, 8'h00, 8'h41, 8'h00, 32'h80, 0, "R3 disp8 neg");
    parse(0, 8'h00, 8'h7A, 8'h00, 32'h7F, 1, "R3 disp8 pos");
    parse(0, 8'h00, 8'h93, 8'h00, 32'hA1B2C3D4, 0, "R3 disp32");
    parse(0, 8'h00, 8'h05, 8'h00, 32'h12345678, 0, "R4 nobase");
    parse(0, 8'h00, 8'h0E, 8'h00, 32'h0, 0, "R4 indirect");
    parse(0, 8'h00, 8'h04, 8'hE2, 32'h0, 0, "R5 noindex");
    parse(0, 8'h00, 8'h04, 8'h9D, 32'hCAFEF00D, 0, "R6 sib nobase");
    parse(0, 8'h00, 8'h44, 8'h1D, 32'hF0, 0, "R6 sib base5");
    parse(1, 8'h47, 8'h54, 8'h65, 32'h11223344, 1, "R7 rex");
    parse(1, 8'h42, 8'h04, 8'h23, 32'h0, 0, "R7 rex index12");
    parse(0, 8'h47, 8'hD4, 8'h00, 32'h0, 0, "R7 no rex 32bit");
    parse(1, 8'h57, 8'hFF, 8'h00, 32'h0, 0, "R7 out of range");

    // R9: restart mid-parse, byte on the start cycle is not consumed
    do_start(0, 8'h00);
    byte_valid_i = 1'b1; byte_i = 8'h82; @(negedge clk);
    byte_i = 8'h01; @(negedge clk);
    long_mode_i = 0; start_i = 1'b1; byte_i = 8'h00; @(negedge clk);
    start_i = 1'b0;
    chk(!done_o, "R9", "no done after abort", 32'(done_o), 0);
    byte_i = 8'hC3; @(negedge clk);
    byte_valid_i = 1'b0;
    chk(done_o && mod_o == 2'b11 && len_o == 1, "R9", "restart parse",
        {27'h0, done_o, mod_o, len_o}, {27'h0, 1'b1, 2'b11, 3'd1});

    // R8: bytes in idle are ignored
    seen = 0;
    byte_valid_i = 1'b1;
    for (int k = 0; k < 8; k++) begin byte_i = 8'hC0; @(negedge clk); if (done_o) seen = 1; end
    byte_valid_i = 1'b0;
    chk(!seen, "R8", "idle ignores bytes", 32'(seen), 0);

    for (int i = 0; i < 300; i++) begin
      logic [7:0] p;
      p = ($urandom % 2) ? {4'h4, 4'($urandom)} : 8'($urandom);
      parse($urandom % 2, p, $urandom, $urandom, $urandom, $urandom % 2, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule